// File: doc/BRIEF.md
# Latched Fault Status Register

This block gathers diagnostic fault flags from a set of output channels, plus two supervisory events, into one sticky status word. A supervisory event is either a falling edge on an external reset line or a low level on an external enable line. A fault flag that pulses high for a single clock is held until software collects it. Software reads the word through a request/response stream. Every accepted read returns a snapshot of the word and clears it in the same cycle. Software can also write a mask word that keeps selected status bits from driving the summary fault pin.

The read path is a valid/ready pair for requests and another for responses. A request is accepted only while `req_ready` is high. `req_ready` is high when no response is waiting, or when the waiting response is taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays on the port unchanged and no new read is accepted. Nothing is cleared until a request is accepted. The mask write port is a plain single-cycle strobe.

The status word has NF = CHANNELS*FLAGS_PER_CH fault bits, followed by two supervisory bits, W = NF+2 bits in total. The two supervisory bits have their own re-arm rules. The reset-event bit is set once for each falling edge of the reset line. The enable-low bit keeps setting itself for as long as the enable line is low.

Top module: `fault_status_reg`

## Requirements
- R1: Status bit c*FLAGS_PER_CH+k reads 1 once `fault_i[c*FLAGS_PER_CH+k]` has been high at any clock edge. It stays 1 until a read is accepted, even after the input returns low.
- R2: An accepted read returns the status word as it stood in the accepting cycle. The response appears on `rsp_data` with `rsp_valid` high one cycle later. All status bits are cleared except those set again in that same cycle.
- R3: A fault input that is high in the same cycle as an accepted read does not appear in that response. It is present in the next read.
- R4: `fault_o` is registered. It is 1 exactly when some status bit is 1 and the mask bit at the same position is 0, with one cycle of delay after the status changes. `wr_en` loads `wr_data` into the mask, which has the same bit layout as the status word.
- R5: Bit NF (reset event) is set by a falling edge of `rst_in_n`, after a two-flip-flop synchronizer. After a read clears it, it stays 0 while `rst_in_n` remains low, and it is set again only by the next falling edge.
- R6: Bit NF+1 (enable low) is set while the synchronized `en_in` is 0. A read clears it only if `en_in` is high, so reads taken while enable is low keep returning 1.
- R7: `req_ready` = !`rsp_valid` || `rsp_ready`. A stalled response holds `rsp_data` stable. A request that is not accepted leaves the status word uncleared.
- R8: After reset the status word and the mask are 0, and `fault_o`, `rsp_valid` and `rsp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NF | Per-channel fault flags, synchronous, active high |
| rst_in_n | input | 1 | Supervised reset line, asynchronous |
| en_in | input | 1 | Supervised enable line, asynchronous |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | W | Snapshot of the status word |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | W | New mask value |
| fault_o | output | 1 | Registered summary of unmasked latched bits |

## Verification
Random single-cycle fault pulses under random masks show whether short pulses are held, and whether the pin follows only unmasked bits. Reads taken while a fault pulse is present tell a correct clear apart from one that drops same-cycle arrivals. A reset line held low across two reads separates edge-triggered re-arming from level sensing. An enable line held low across two reads, then raised, shows the conditional clear. A stalled response with a repeated request shows whether the hold is correct and whether an early clear happens.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  // Positions of the supervisory bits above the fault field
  localparam int RST_EV_OFS = 0;
  localparam int EN_LOW_OFS = 1;
  localparam int SUP_BITS   = 2;

  function automatic int stat_width(input int nfault);
    return nfault + SUP_BITS;
  endfunction
endpackage

// File: rtl/fsr_sync.sv
// Two-stage synchronizer bank with a selectable reset level per bit
module fsr_sync #(
  parameter int          WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        sync_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b] <= async_i[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/fsr_events.sv
// Turns synchronized supervisory lines into status set requests
module fsr_events (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_line_s,
  input  logic en_line_s,
  output logic rst_fall,
  output logic en_low
);
  logic rst_line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_line_d <= 1'b1;
    else        rst_line_d <= rst_line_s;
  end

  assign rst_fall = rst_line_d & ~rst_line_s;
  assign en_low   = ~en_line_s;

  // R5
  rst_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fall |=> !rst_fall);
endmodule

// File: rtl/fsr_latch.sv
// Sticky status word: set has priority over the read clear
module fsr_latch #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] stat_q
);
  logic [WIDTH-1:0] keep;

  assign keep = clr_i ? '0 : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= keep | set_i;
  end

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R3
  same_cycle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fsr_pin.sv
// Mask register and registered summary fault pin
module fsr_pin #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stat_i,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             fault_o
);
  logic [WIDTH-1:0] mask_q;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end

  assign hit = |(stat_i & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_o <= 1'b0;
    else        fault_o <= hit;
  end

  // R4
  pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(stat_i) != '0);

  // R4
  pin_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |=> !fault_o);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int CHANNELS     = 2,
  parameter int FLAGS_PER_CH = 4,
  localparam int NF = CHANNELS * FLAGS_PER_CH,
  localparam int W  = fsr_pkg::stat_width(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_i,
  input  logic          rst_in_n,
  input  logic          en_in,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [W-1:0]  rsp_data,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic          fault_o
);
  import fsr_pkg::*;

  logic [1:0]   sup_s;
  logic         rst_fall, en_low;
  logic [W-1:0] set_vec, stat_q;
  logic         take;

  fsr_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({en_in, rst_in_n}),
    .sync_o(sup_s)
  );

  fsr_events u_events (
    .clk(clk), .rst_n(rst_n),
    .rst_line_s(sup_s[0]), .en_line_s(sup_s[1]),
    .rst_fall(rst_fall), .en_low(en_low)
  );

  always_comb begin
    set_vec = '0;
    set_vec[NF-1:0]           = fault_i;
    set_vec[NF + RST_EV_OFS]  = rst_fall;
    set_vec[NF + EN_LOW_OFS]  = en_low;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  fsr_latch #(.WIDTH(W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .set_i(set_vec), .clr_i(take),
    .stat_q(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= stat_q;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  fsr_pin #(.WIDTH(W)) u_pin (
    .clk(clk), .rst_n(rst_n),
    .stat_i(stat_q),
    .wr_en(wr_en), .wr_data(wr_data),
    .fault_o(fault_o)
  );

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R6
  en_low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_low |=> stat_q[NF + EN_LOW_OFS]);

  // R2
  rsp_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);
endmodule

// File: tb/test_fault_status_reg.sv
module test_fault_status_reg;
  localparam int CH = 2, FPC = 4, NF = CH * FPC, W = NF + 2;
  localparam int RL = NF, ENL = NF + 1;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] fault_i = '0;
  logic rst_in_n = 1, en_in = 1;
  logic req_valid = 0, rsp_ready = 1, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic req_ready, rsp_valid, fault_o;
  logic [W-1:0] rsp_data;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_status_reg #(.CHANNELS(CH), .FLAGS_PER_CH(FPC)) i_fault_status_reg (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .rst_in_n(rst_in_n),
    .en_in(en_in), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_en(wr_en), .wr_data(wr_data), .fault_o(fault_o)
  );

  function automatic logic exp_pin(input logic [W-1:0] st, input logic [W-1:0] m);
    return |(st & ~m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_word(output logic [W-1:0] d);
    @(negedge clk) req_valid = 1;
    @(negedge clk) req_valid = 0;
    d = rsp_data;
    check("R2 rsp_valid", rsp_valid, 1);
  endtask

  task automatic pulse(input logic [NF-1:0] v);
    @(negedge clk) fault_i = v;
    @(negedge clk) fault_i = '0;
  endtask

  task automatic set_mask(input logic [W-1:0] m);
    @(negedge clk) begin wr_en = 1; wr_data = m; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [W-1:0] d, acc, m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 fault_o", fault_o, 0);
    check("R8 rsp_valid", rsp_valid, 0);
    check("R8 rsp_data", rsp_data, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    read_word(d);
    check("R8 status after reset", d, 0);

    // R1 single pulse held, pin follows
    pulse(8'h01 << 3);
    @(negedge clk);
    check("R1/R4 pin set", fault_o, 1);
    repeat (3) @(negedge clk);
    check("R1 pin still set", fault_o, 1);
    read_word(d);
    check("R1 latched bit", d, W'(1) << 3);
    @(negedge clk);
    check("R2 pin cleared after read", fault_o, 0);
    read_word(d);
    check("R2 cleared", d, 0);

    // R3 fault arriving with the read
    @(negedge clk) begin req_valid = 1; fault_i = 8'h82; end
    @(negedge clk) begin req_valid = 0; fault_i = '0; end
    check("R3 not in this response", rsp_data, 0);
    read_word(d);
    check("R3 kept for next read", d, W'(8'h82));

    // R4 masking
    set_mask(W'(8'h10));
    pulse(8'h10);
    @(negedge clk);
    check("R4 masked bit no pin", fault_o, 0);
    set_mask('0);
    @(negedge clk);
    check("R4 unmask raises pin", fault_o, 1);
    read_word(d);
    check("R4 masked bit still latched", d, W'(8'h10));

    // R5 reset-line falling edge
    @(negedge clk) rst_in_n = 0;
    repeat (5) @(negedge clk);
    read_word(d);
    check("R5 edge sets bit", d[RL], 1);
    repeat (3) @(negedge clk);
    read_word(d);
    check("R5 no re-set while low", d[RL], 0);
    @(negedge clk) rst_in_n = 1;
    repeat (5) @(negedge clk);
    read_word(d);
    check("R5 rising edge ignored", d[RL], 0);
    @(negedge clk) rst_in_n = 0;
    repeat (5) @(negedge clk);
    read_word(d);
    check("R5 next edge sets again", d[RL], 1);
    @(negedge clk) rst_in_n = 1;
    repeat (4) @(negedge clk);

    // R6 enable low
    @(negedge clk) en_in = 0;
    repeat (5) @(negedge clk);
    read_word(d);
    check("R6 low sets bit", d[ENL], 1);
    read_word(d);
    check("R6 read while low keeps bit", d[ENL], 1);
    @(negedge clk) en_in = 1;
    repeat (5) @(negedge clk);
    read_word(d);
    check("R6 still set until read with enable high", d[ENL], 1);
    read_word(d);
    check("R6 cleared", d, 0);

    // R7 back-pressure
    pulse(8'h04);
    @(negedge clk) begin rsp_ready = 0; req_valid = 1; end
    @(negedge clk);
    check("R7 rsp_valid", rsp_valid, 1);
    check("R7 req_ready low", req_ready, 0);
    fault_i = 8'h40;
    @(negedge clk) fault_i = '0;
    @(negedge clk);
    check("R7 data held", rsp_data, W'(8'h04));
    @(negedge clk) begin req_valid = 0; rsp_ready = 1; end
    @(negedge clk);
    check("R7 rsp drained", rsp_valid, 0);
    read_word(d);
    check("R7 stalled request did not clear", d, W'(8'h40));

    // Random: R1 R2 R4
    for (int it = 0; it < 40; it++) begin
      m = W'($urandom);
      set_mask(m);
      acc = '0;
      for (int p = 0; p < 1 + int'($urandom % 3); p++) begin
        logic [NF-1:0] v;
        v = NF'($urandom) & NF'($urandom);
        acc |= W'(v);
        pulse(v);
      end
      @(negedge clk);
      check("R4 random pin", fault_o, exp_pin(acc, m));
      read_word(d);
      check("R1 random latch", d, acc);
      @(negedge clk);
      check("R2 random pin after clear", fault_o, 0);
    end
    finish_up();
  end
endmodule